// File: doc/BRIEF.md
# Push-Button Up/Down Address Counter

This block turns two mechanical push buttons into a clean 16-bit up/down count. Every register runs on one free-running master clock, and the buttons never act as clocks. A prescaler makes a one-cycle enable pulse about every 10 ms, which is roughly 100 Hz. Only on that pulse are the two button levels sampled. Each raw level first passes through a two-flop synchroniser.

Each new sample is compared with the sample taken before it. A released-to-pressed change produces a single-cycle step pulse. The counter adds the up step and subtracts the down step in the same cycle. So a held button moves the count once, contact bounce that settles inside one sample period adds nothing, and simultaneous presses cancel.

A typical use is an address selector that a person dials with two buttons while a display shows the value.

Top module: `pushbtn_addr_counter`

## Requirements
- R1: The count is 16 bits wide. An up step from 0xFFFF gives 0x0000.
- R2: A down step from 0x0000 gives 0xFFFF.
- R3: A low level on `rst_n` clears the count to 0x0000 at once, without waiting for a clock edge. Reset overrides any pending step.
- R4: One press of up (or down), held across several sample periods, changes the count by exactly +1 (or −1). The count never moves by more than one per clock cycle.
- R5: If an up step and a down step fall in the same cycle, the count is unchanged.
- R6: A button held pressed gives no further step until it has been sampled released and then pressed again.
- R7: The sample enable is one clock wide and recurs every `SAMPLE_DIV` cycles. After reset release, the first pulse is visible after clock edge `SAMPLE_DIV`, and the first sample is taken at edge `SAMPLE_DIV`+1.
- R8: Each button passes through a two-flop synchroniser. The sample taken at edge n sees the raw level that was present at edge n−2. A step found at edge n shows on `count_o` after edge n+1.
- R9: After reset the stored samples mean "released". A button held through reset therefore counts once, at the first sample after release, so the count reads 1 after edge `SAMPLE_DIV`+2.
- R10: Bouncing shorter than one sample period, on press or on release, gives no extra step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_up_i | input | 1 | Raw up button, 1 = pressed, asynchronous |
| btn_dn_i | input | 1 | Raw down button, 1 = pressed, asynchronous |
| count_o | output | 16 | Current count value |

## Verification
Two functions can fall in the same cycle: an up step and a down step can reach the adder together. The bench provokes this by pressing both buttons in the same cycle, so one sample catches both edges. It expects the count to be unchanged, and the cycle-by-cycle reference model also resolves it as a net zero change. The other coincidence is reset against a pending step. The bench asserts reset while a press is in flight and expects 0x0000 at once, not one step later.

// File: rtl/pushbtn_cnt_pkg.sv
package pushbtn_cnt_pkg;

    localparam int NUM_BTN = 2;

    typedef enum int {
        BTN_INC = 0,
        BTN_DEC = 1
    } btn_idx_e;

endpackage

// File: rtl/pbc_prescaler.sv
module pbc_prescaler #(
    parameter int SAMPLE_DIV = 320000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(SAMPLE_DIV - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic          tick;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.div == LAST) begin
            st_d.div  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.div  = st_q.div + DW'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/pbc_button_front.sv
module pbc_button_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic tick_i,
    output logic step_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic                   step;
    } front_t;

    front_t st_d, st_q;
    logic   synced;

    assign synced = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_i};
        st_d.step = 1'b0;
        if (tick_i) begin
            st_d.last = synced;
            st_d.step = synced & ~st_q.last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o = st_q.step;
endmodule

// File: rtl/pbc_step_counter.sv
module pbc_step_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.count = st_q.count + CNT_W'(inc_i) - CNT_W'(dec_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/pushbtn_addr_counter.sv
module pushbtn_addr_counter
    import pushbtn_cnt_pkg::*;
#(
    parameter int SAMPLE_DIV  = 320000,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_up_i,
    input  logic             btn_dn_i,
    output logic [CNT_W-1:0] count_o
);
    logic               tick;
    logic [NUM_BTN-1:0] raw;
    logic [NUM_BTN-1:0] step;
    logic               up_step;
    logic               dn_step;

    assign raw[BTN_INC] = btn_up_i;
    assign raw[BTN_DEC] = btn_dn_i;

    pbc_prescaler #(.SAMPLE_DIV(SAMPLE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        pbc_button_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[b]),
            .tick_i (tick),
            .step_o (step[b])
        );
    end

    assign up_step = step[BTN_INC];
    assign dn_step = step[BTN_DEC];

    pbc_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (up_step),
        .dec_i   (dn_step),
        .count_o (count_o)
    );
endmodule

// File: rtl/pushbtn_addr_counter_chk.sv
module pushbtn_addr_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             up_step,
    input logic             dn_step,
    input logic [CNT_W-1:0] count
);
    // R3: whenever reset is low at an edge the count already reads zero
    p_reset_clear_r3: assert property (@(posedge clk) !rst_n |-> count == '0);

    // R4: the count moves by at most one per cycle
    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)
                  || count == CNT_W'($past(count) - 1'b1)));

    // R4 and R1: a lone up step adds one, wrapping
    p_up_adds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_step && !dn_step) |=> count == CNT_W'($past(count) + 1'b1));

    // R2: a lone down step subtracts one, wrapping
    p_dn_subs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_step && !up_step) |=> count == CNT_W'($past(count) - 1'b1));

    // R5: coincident steps cancel
    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_step && dn_step) |=> $stable(count));

    // R7: the enable pulse is one cycle wide
    p_tick_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: a step only appears in the cycle after a sample enable
    p_step_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_step || dn_step) |-> $past(tick));

    // R6: a step pulse never lasts two cycles
    p_step_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_step |=> !up_step);
endmodule

bind pushbtn_addr_counter pushbtn_addr_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .up_step (up_step),
    .dn_step (dn_step),
    .count   (count_o)
);

// File: tb/pushbtn_addr_counter_tb.sv
module pushbtn_addr_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn_up = 1'b0;
    logic        btn_dn = 1'b0;
    logic [15:0] count;

    int total = 0;
    int bad   = 0;

    pushbtn_addr_counter #(.SAMPLE_DIV(DIV)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_up_i (btn_up),
        .btn_dn_i (btn_dn),
        .count_o  (count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: edge count since reset, raw history queues
    int n;
    int m_cnt;
    bit prev_u, prev_d, pend_u, pend_d;
    bit hu[$];
    bit hd[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n = 0; m_cnt = 0;
            prev_u = 0; prev_d = 0; pend_u = 0; pend_d = 0;
            hu.delete(); hd.delete();
        end else begin
            bit su, sd;
            n++;
            m_cnt = (m_cnt + int'(pend_u) - int'(pend_d)) & 16'hFFFF;
            pend_u = 0; pend_d = 0;
            hu.push_front(btn_up);
            hd.push_front(btn_dn);
            if (hu.size() > 3) begin void'(hu.pop_back()); void'(hd.pop_back()); end
            if (n > 1 && (n - 1) % DIV == 0) begin
                su = (hu.size() > 2) ? hu[2] : 1'b0;
                sd = (hd.size() > 2) ? hd[2] : 1'b0;
                pend_u = su && !prev_u;
                pend_d = sd && !prev_d;
                prev_u = su;
                prev_d = sd;
            end
        end
    end

    // cycle-by-cycle comparison (R4, R5, R6, R8, R10 via the model)
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (count !== 16'(m_cnt)) begin
                bad++;
                $display("FAIL R4 model compare at edge %0d: actual=%h expected=%h", n, count, 16'(m_cnt));
            end
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        edges(3);
        rst_n = 1'b1;
    endtask

    task automatic press(bit up, bit dn);
        btn_up = up; btn_dn = dn;
        edges(5 * DIV);
        btn_up = 1'b0; btn_dn = 1'b0;
        edges(3 * DIV);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        edges(3);
        check("R3 reset value", count, 16'h0000);
        rst_n = 1'b1;

        // R7: first sample at edge DIV+1, so count holds until edge DIV+2
        btn_up = 1'b1;
        edges(DIV + 1);
        check("R7 no step before first sample", count, 16'h0000);
        edges(1);
        check("R7 first sample counted", count, 16'h0001);
        btn_up = 1'b0;
        edges(3 * DIV);
        check("R6 held press counted once", count, 16'h0001);

        press(0, 1);
        check("R4 down press", count, 16'h0000);
        press(0, 1);
        check("R2 wrap down", count, 16'hFFFF);
        press(1, 0);
        check("R1 wrap up", count, 16'h0000);
        press(1, 0);
        check("R4 up press", count, 16'h0001);
        press(1, 1);
        check("R5 simultaneous cancel", count, 16'h0001);

        // R10: bounce shorter than one period on press and on release
        for (int i = 0; i < 3; i++) begin btn_up = ~btn_up; edges(1); end
        btn_up = 1'b1;
        edges(4 * DIV);
        for (int i = 0; i < 3; i++) begin btn_up = ~btn_up; edges(1); end
        btn_up = 1'b0;
        edges(3 * DIV);
        check("R10 bounce gives one step", count, 16'h0002);

        // R3: reset overrides a pending step, takes effect without a clock
        btn_up = 1'b1;
        edges(DIV + 2);
        #1 rst_n = 1'b0;
        #1 check("R3 asynchronous clear", count, 16'h0000);
        edges(2);
        check("R3 held in reset", count, 16'h0000);

        // R9: button held through reset counts once
        rst_n = 1'b1;
        edges(DIV + 1);
        check("R9 not yet counted", count, 16'h0000);
        edges(1);
        check("R9 counted once after reset", count, 16'h0001);
        btn_up = 1'b0;
        edges(3 * DIV);

        // R8: raw level first present at edge DIV misses the sample at DIV+1
        btn_up = 1'b0;
        do_reset();
        edges(DIV - 1);
        btn_up = 1'b1;
        edges(DIV + 2);
        check("R8 synchroniser latency miss", count, 16'h0000);
        edges(1);
        check("R8 counted at next sample", count, 16'h0001);
        btn_up = 1'b0;
        edges(3 * DIV);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule